// File: doc/BRIEF.md
# Dual Potentiometer Setting Bank Controller

This block keeps the stored settings of two digitally controlled potentiometers: four 6-bit data registers per pot, emulating nonvolatile storage in on-chip memory. A bus front end hands it one decoded command per cycle. The commands cover four kinds of work. A register can be read or written directly. A single pot can copy one of its registers into its wiper register, or save its wiper into one of its registers. Both pots can do either copy at once, using the same register pointer. The wiper registers themselves sit outside the block. The block reads their current values on an input bus and loads them through a one-cycle load strobe with a value per pot.

Each command that writes storage models the slow nonvolatile write cycle. The block raises busy for a fixed number of clock cycles, set by a parameter, and drops its ready output for that whole window. The bus front end uses ready to decide whether to acknowledge its address, so a host can poll until the write completes. The register contents survive a synchronous reset. When reset is released, the block recalls register 0 of every pot into that pot's wiper.

Top module: `pot_bank_ctrl`

## Requirements
- R1: While `rst` is high, `busy_o`, `rd_valid_o`, `wcr_ld_o` and `cmd_ready_o` are all 0.
- R2: In the second cycle after reset is released, `wcr_ld_o` pulses with every bit set. Each pot's load value is its register 0. Register contents are not changed by reset. At start-up, register r of pot p holds INIT_SEED + 4*p + r, truncated to 6 bits.
- R3: Opcode 0 (read) accepted in cycle T gives `rd_valid_o` high for one cycle in T+1. In that cycle `rd_data_o` carries the selected register zero-extended to 8 bits.
- R4: Opcode 1 (write) stores `cmd_wdata_i[5:0]` into the selected register. Bits 7:6 are ignored.
- R5: Opcode 2 (fetch) accepted in cycle T pulses only the selected pot's `wcr_ld_o` bit in T+2, with that pot's register value.
- R6: Opcode 3 (save) stores the selected pot's current wiper input into that pot's selected register.
- R7: Opcode 4 (fetch all) loads register `cmd_ptr_i` of each pot into that pot's own wiper, all in the same cycle T+2. The pot field is ignored.
- R8: Opcode 5 (save all) stores each pot's wiper input into that pot's register `cmd_ptr_i`, all at once.
- R9: Opcodes 1, 3 and 5 raise `busy_o` from cycle T+1 for exactly WRITE_CYCLES cycles. Opcodes 0, 2 and 4 never raise it.
- R10: `cmd_ready_o` is low while busy and in the recall cycle. A command presented then has no effect: no read, no load, no store, and no extension of busy.
- R11: Opcodes 6 and 7 have no effect on any output or register.
- R12: A reset during a busy window ends it. Busy is low after release, and the write that started the window is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Opcode (0 read, 1 write, 2 fetch, 3 save, 4 fetch all, 5 save all) |
| cmd_pot_i | input | POT_SEL_W (1) | Selected pot |
| cmd_ptr_i | input | PTR_W (2) | Register pointer within a pot |
| cmd_wdata_i | input | DATA_W (8) | Write data for opcode 1 |
| cmd_ready_o | output | 1 | Command will be accepted (drives bus acknowledge) |
| rd_valid_o | output | 1 | Read data valid strobe |
| rd_data_o | output | DATA_W (8) | Zero-extended register value |
| wcr_cur_i | input | POTS*WIPER_W (12) | Current wiper values, pot 0 in the low bits |
| wcr_ld_o | output | POTS (2) | One-cycle wiper load strobe per pot |
| wcr_ld_val_o | output | POTS*WIPER_W (12) | Wiper load values, pot 0 in the low bits |
| busy_o | output | 1 | Storage write cycle in progress |

## Verification
A table of commands first reads registers in their start-up pattern. Every value in that pattern differs, so a wrong pot or pointer decode shows up as a wrong number. Writes carry set upper bits, to catch any failure to drop bits 7:6. Each write is read back through a different path from the one that stored it. Single and global transfers are interleaved so that the load strobe mask separates single-pot from both-pot behaviour. Directed tests then present writes, reads and fetches throughout a busy window and count its length, to show that these commands are discarded and do not restart the timer. A reset inside a busy window checks the recall values, which must show the retained contents rather than the start-up pattern.

// File: rtl/pot_bank_pkg.sv
package pot_bank_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_FETCH     = 3'd2,
    OP_SAVE      = 3'd3,
    OP_FETCH_ALL = 3'd4,
    OP_SAVE_ALL  = 3'd5
  } pot_op_e;

endpackage

// File: rtl/pot_reg_store.sv
// Register storage for one pot: one write port, one registered read port.
// No reset on the array so it survives rst and maps onto block RAM.
module pot_reg_store #(
  parameter int WIDTH     = 6,
  parameter int DEPTH     = 4,
  parameter int INIT_BASE = 0,
  localparam int ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WIDTH-1:0]  rdata_o
);

  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = WIDTH'(INIT_BASE + i);
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/pot_busy_timer.sv
// Nonvolatile write window: busy for exactly CYCLES cycles after start.
module pot_busy_timer #(
  parameter int CYCLES = 40,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(CYCLES);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
      busy_q <= (cnt_q != CNT_W'(1));
    end
  end

  assign busy_o = busy_q;

  // R9
  start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q);

  // R9
  busy_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q != '0) && (cnt_q <= CNT_W'(CYCLES)));

endmodule

// File: rtl/pot_cmd_decode.sv
// Turns an accepted command (or the post-reset recall) into per-pot
// storage strobes, load requests and a busy start.
module pot_cmd_decode
  import pot_bank_pkg::*;
#(
  parameter int POTS      = 2,
  parameter int POT_SEL_W = 1
) (
  input  logic                 recall_i,
  input  logic                 accept_i,
  input  logic [OP_W-1:0]      op_i,
  input  logic [POT_SEL_W-1:0] pot_i,
  output logic [POTS-1:0]      we_o,
  output logic [POTS-1:0]      re_o,
  output logic [POTS-1:0]      ld_req_o,
  output logic                 wsrc_wiper_o,
  output logic                 rd_req_o,
  output logic                 start_o
);

  logic [POTS-1:0] sel;

  always_comb begin
    for (int p = 0; p < POTS; p++) sel[p] = (pot_i == POT_SEL_W'(p));
  end

  always_comb begin
    we_o         = '0;
    re_o         = '0;
    ld_req_o     = '0;
    wsrc_wiper_o = 1'b0;
    rd_req_o     = 1'b0;
    start_o      = 1'b0;
    if (recall_i) begin
      re_o     = '1;
      ld_req_o = '1;
    end else if (accept_i) begin
      case (op_i)
        OP_READ: begin
          re_o     = sel;
          rd_req_o = 1'b1;
        end
        OP_WRITE: begin
          we_o    = sel;
          start_o = 1'b1;
        end
        OP_FETCH: begin
          re_o     = sel;
          ld_req_o = sel;
        end
        OP_SAVE: begin
          we_o         = sel;
          wsrc_wiper_o = 1'b1;
          start_o      = 1'b1;
        end
        OP_FETCH_ALL: begin
          re_o     = '1;
          ld_req_o = '1;
        end
        OP_SAVE_ALL: begin
          we_o         = '1;
          wsrc_wiper_o = 1'b1;
          start_o      = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pot_bank_ctrl.sv
module pot_bank_ctrl
  import pot_bank_pkg::*;
#(
  parameter int POTS         = 2,
  parameter int REGS         = 4,
  parameter int WIPER_W      = 6,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 40,
  parameter int INIT_SEED    = 5,
  localparam int POT_SEL_W   = (POTS > 1) ? $clog2(POTS) : 1,
  localparam int PTR_W       = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_valid_i,
  input  logic [OP_W-1:0]           cmd_op_i,
  input  logic [POT_SEL_W-1:0]      cmd_pot_i,
  input  logic [PTR_W-1:0]          cmd_ptr_i,
  input  logic [DATA_W-1:0]         cmd_wdata_i,
  output logic                      cmd_ready_o,
  output logic                      rd_valid_o,
  output logic [DATA_W-1:0]         rd_data_o,
  input  logic [POTS*WIPER_W-1:0]   wcr_cur_i,
  output logic [POTS-1:0]           wcr_ld_o,
  output logic [POTS*WIPER_W-1:0]   wcr_ld_val_o,
  output logic                      busy_o
);

  logic                 recall_q;
  logic                 accept;
  logic [POTS-1:0]      store_we;
  logic [POTS-1:0]      store_re;
  logic [POTS-1:0]      ld_req;
  logic                 wsrc_wiper;
  logic                 rd_req;
  logic                 busy_start;
  logic [PTR_W-1:0]     addr;
  logic [WIPER_W-1:0]   store_q [POTS];
  logic [POTS-1:0]      ld_pend_q;
  logic [POTS-1:0]      ld_q;
  logic [WIPER_W-1:0]   ld_val_q [POTS];
  logic                 rd_valid_q;
  logic [POT_SEL_W-1:0] rd_pot_q;

  assign cmd_ready_o = !rst && !recall_q && !busy_o;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign addr        = recall_q ? '0 : cmd_ptr_i;

  // Recall of register 0 is pending from reset until the first free cycle.
  always_ff @(posedge clk) begin
    if (rst) recall_q <= 1'b1;
    else     recall_q <= 1'b0;
  end

  pot_cmd_decode #(
    .POTS      (POTS),
    .POT_SEL_W (POT_SEL_W)
  ) i_decode (
    .recall_i     (recall_q && !rst),
    .accept_i     (accept),
    .op_i         (cmd_op_i),
    .pot_i        (cmd_pot_i),
    .we_o         (store_we),
    .re_o         (store_re),
    .ld_req_o     (ld_req),
    .wsrc_wiper_o (wsrc_wiper),
    .rd_req_o     (rd_req),
    .start_o      (busy_start)
  );

  pot_busy_timer #(
    .CYCLES (WRITE_CYCLES)
  ) i_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (busy_start),
    .busy_o  (busy_o)
  );

  for (genvar p = 0; p < POTS; p++) begin : g_pot
    logic [WIPER_W-1:0] wdata;
    assign wdata = wsrc_wiper ? wcr_cur_i[p*WIPER_W +: WIPER_W]
                              : cmd_wdata_i[WIPER_W-1:0];

    pot_reg_store #(
      .WIDTH     (WIPER_W),
      .DEPTH     (REGS),
      .INIT_BASE (INIT_SEED + p*REGS)
    ) i_store (
      .clk     (clk),
      .we_i    (store_we[p]),
      .waddr_i (addr),
      .wdata_i (wdata),
      .re_i    (store_re[p]),
      .raddr_i (addr),
      .rdata_o (store_q[p])
    );

    always_ff @(posedge clk) begin
      if (ld_pend_q[p]) ld_val_q[p] <= store_q[p];
    end

    assign wcr_ld_val_o[p*WIPER_W +: WIPER_W] = ld_val_q[p];
  end

  // Load path: storage read in one cycle, wiper strobe the next.
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_pend_q  <= '0;
      ld_q       <= '0;
      rd_valid_q <= 1'b0;
      rd_pot_q   <= '0;
    end else begin
      ld_pend_q  <= ld_req;
      ld_q       <= ld_pend_q;
      rd_valid_q <= rd_req;
      if (rd_req) rd_pot_q <= cmd_pot_i;
    end
  end

  assign wcr_ld_o   = ld_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = {{(DATA_W-WIPER_W){1'b0}}, store_q[rd_pot_q]};

  // R3
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(cmd_valid_i && cmd_ready_o && (cmd_op_i == OP_READ)));

  // R10
  no_store_write_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (store_we == '0));

  // R10
  ld_not_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (|wcr_ld_o) |-> !$past(busy_o, 2));

  // R2
  recall_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    recall_q |-> ##2 (&wcr_ld_o));

endmodule

// File: tb/test_pot_bank_ctrl.sv
module test_pot_bank_ctrl;

  localparam int WC = 40;

  typedef struct packed {
    logic [2:0] op;
    logic       pot;
    logic [1:0] ptr;
    logic [7:0] wd;
    logic [7:0] exp_rd;
    logic [1:0] exp_ld;
    logic [5:0] exp_v0;
    logic [5:0] exp_v1;
    logic       exp_busy;
  } vec_t;

  localparam int NV = 14;
  // Start-up: pot0 regs 5,6,7,8; pot1 regs 9,10,11,12; wipers after recall 5 / 9.
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'd1, 2'd2, 8'd0,    8'd11, 2'b00, 6'd0,  6'd0,  1'b0}, // R3 read p1 r2
    '{3'd1, 1'd0, 2'd1, 8'hEA,   8'd0,  2'b00, 6'd0,  6'd0,  1'b1}, // R4 write 0x2A
    '{3'd0, 1'd0, 2'd1, 8'd0,    8'd42, 2'b00, 6'd0,  6'd0,  1'b0}, // R4 readback
    '{3'd2, 1'd1, 2'd3, 8'd0,    8'd0,  2'b10, 6'd0,  6'd12, 1'b0}, // R5 fetch p1 r3
    '{3'd3, 1'd1, 2'd0, 8'd0,    8'd0,  2'b00, 6'd0,  6'd0,  1'b1}, // R6 save p1 -> r0
    '{3'd0, 1'd1, 2'd0, 8'd0,    8'd12, 2'b00, 6'd0,  6'd0,  1'b0}, // R6 readback
    '{3'd4, 1'd1, 2'd1, 8'd0,    8'd0,  2'b11, 6'd42, 6'd10, 1'b0}, // R7 fetch all r1
    '{3'd1, 1'd1, 2'd3, 8'hFF,   8'd0,  2'b00, 6'd0,  6'd0,  1'b1}, // R4 write 63
    '{3'd5, 1'd0, 2'd2, 8'd0,    8'd0,  2'b00, 6'd0,  6'd0,  1'b1}, // R8 save all r2
    '{3'd0, 1'd0, 2'd2, 8'd0,    8'd42, 2'b00, 6'd0,  6'd0,  1'b0}, // R8 p0
    '{3'd0, 1'd1, 2'd2, 8'd0,    8'd10, 2'b00, 6'd0,  6'd0,  1'b0}, // R8 p1
    '{3'd0, 1'd1, 2'd3, 8'd0,    8'd63, 2'b00, 6'd0,  6'd0,  1'b0}, // R4 p1 r3
    '{3'd6, 1'd0, 2'd0, 8'd9,    8'd0,  2'b00, 6'd0,  6'd0,  1'b0}, // R11 undefined
    '{3'd0, 1'd0, 2'd0, 8'd0,    8'd5,  2'b00, 6'd0,  6'd0,  1'b0}  // R11 p0 r0 intact
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic        cmd_pot = 1'b0;
  logic [1:0]  cmd_ptr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        cmd_ready;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [5:0]  w0 = '0;
  logic [5:0]  w1 = '0;
  logic [1:0]  wcr_ld;
  logic [11:0] wcr_ld_val;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pot_bank_ctrl #(.WRITE_CYCLES(WC)) i_pot_bank_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid_i  (cmd_valid),
    .cmd_op_i     (cmd_op),
    .cmd_pot_i    (cmd_pot),
    .cmd_ptr_i    (cmd_ptr),
    .cmd_wdata_i  (cmd_wdata),
    .cmd_ready_o  (cmd_ready),
    .rd_valid_o   (rd_valid),
    .rd_data_o    (rd_data),
    .wcr_cur_i    ({w1, w0}),
    .wcr_ld_o     (wcr_ld),
    .wcr_ld_val_o (wcr_ld_val),
    .busy_o       (busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!cmd_ready) @(negedge clk);
  endtask

  // Emulates the external wiper registers.
  task automatic take_loads();
    if (wcr_ld[0]) w0 = wcr_ld_val[5:0];
    if (wcr_ld[1]) w1 = wcr_ld_val[11:6];
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    string tag;
    tag = $sformatf("vec%0d R3-R11 op%0d", idx, v.op);
    wait_ready();
    cmd_valid = 1'b1; cmd_op = v.op; cmd_pot = v.pot; cmd_ptr = v.ptr; cmd_wdata = v.wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rd_valid == (v.op == 3'd0), {tag, " rd_valid"}, rd_valid, v.op == 3'd0);
    if (v.op == 3'd0) check(rd_data == v.exp_rd, {tag, " rd_data"}, rd_data, v.exp_rd);
    check(busy == v.exp_busy, {tag, " busy R9"}, busy, v.exp_busy);
    @(negedge clk);
    check(wcr_ld == v.exp_ld, {tag, " ld mask"}, wcr_ld, v.exp_ld);
    if (v.exp_ld[0]) check(wcr_ld_val[5:0] == v.exp_v0, {tag, " ld v0"}, wcr_ld_val[5:0], v.exp_v0);
    if (v.exp_ld[1]) check(wcr_ld_val[11:6] == v.exp_v1, {tag, " ld v1"}, wcr_ld_val[11:6], v.exp_v1);
    take_loads();
  endtask

  task automatic read_check(input bit pot, input logic [1:0] ptr, input int exp, input string tag);
    run_vec('{3'd0, pot, ptr, 8'd0, 8'(exp), 2'b00, 6'd0, 6'd0, 1'b0}, 99);
    if (rd_data != 8'(exp)) $display("  note: readback above belongs to %s", tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R1-R12 actual hang expected finish");
      finish_run();
    end
  end

  initial begin
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && rd_valid == 1'b0 && wcr_ld == 2'b00 && cmd_ready == 1'b0,
          "R1 reset outputs", {busy, rd_valid, wcr_ld, cmd_ready}, 0);
    rst = 1'b0;
    // R2 recall of register 0 in second cycle after release
    @(negedge clk);
    check(wcr_ld == 2'b00, "R2 no load in first cycle", wcr_ld, 0);
    @(negedge clk);
    check(wcr_ld == 2'b11, "R2 recall mask", wcr_ld, 3);
    check(wcr_ld_val[5:0] == 6'd5, "R2 recall pot0", wcr_ld_val[5:0], 5);
    check(wcr_ld_val[11:6] == 6'd9, "R2 recall pot1", wcr_ld_val[11:6], 9);
    take_loads();
    @(negedge clk);
    check(wcr_ld == 2'b00, "R2 recall strobe one cycle", wcr_ld, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R9 R10: busy window length with junk commands presented throughout
    wait_ready();
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_pot = 1'b0; cmd_ptr = 2'd3; cmd_wdata = 8'd20;
    @(negedge clk);
    n = 0;
    while (busy && n < 4 * WC) begin
      n++;
      check(cmd_ready == 1'b0, "R10 ready low while busy", cmd_ready, 0);
      check(rd_valid == 1'b0 && wcr_ld == 2'b00, "R10 discarded command effect",
            {rd_valid, wcr_ld}, 0);
      cmd_valid = 1'b1;
      cmd_pot = n[0];
      cmd_ptr = n % 3 == 0 ? 2'd3 : 2'd0;
      cmd_wdata = 8'd33;
      cmd_op = (n % 3 == 0) ? 3'd1 : (n % 3 == 1) ? 3'd0 : 3'd2;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check(n == WC, "R9 busy length", n, WC);
    @(negedge clk);
    check(rd_valid == 1'b0 && wcr_ld == 2'b00, "R10 no late effect", {rd_valid, wcr_ld}, 0);
    read_check(1'b0, 2'd3, 20, "R10 discarded write not stored");
    check(busy == 1'b0, "R9 read does not raise busy", busy, 0);

    // R12: reset inside a busy window, then R2 recall of retained contents
    wait_ready();
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_pot = 1'b1; cmd_ptr = 2'd1; cmd_wdata = 8'd50;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R9 busy mid window", busy, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && cmd_ready == 1'b0, "R1 reset during busy", {busy, cmd_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R12 busy cleared", busy, 0);
    @(negedge clk);
    check(wcr_ld == 2'b11, "R2 recall after second reset", wcr_ld, 3);
    check(wcr_ld_val[5:0] == 6'd5, "R2 retained pot0 r0", wcr_ld_val[5:0], 5);
    check(wcr_ld_val[11:6] == 6'd12, "R2 retained pot1 r0", wcr_ld_val[11:6], 12);
    take_loads();
    read_check(1'b1, 2'd1, 50, "R12 interrupted write kept");
    read_check(1'b0, 2'd3, 20, "R2 contents survive reset");

    done = 1'b1;
    finish_run();
  end

endmodule